// File: doc/BRIEF.md
# Buck Regulator Startup and Soft-Start Sequencer

This block is the digital controller that decides when a step-down regulator may start switching and how it gets to full output. It takes the power-supply-good flag, the signal-supply-good flag, an enable request and an over-temperature flag, and passes each of them through a two-stage synchroniser. When all three start conditions hold and the die is not hot, it waits a fixed number of system clocks. It then ramps a 10-bit reference code by one step per switching tick until the code reaches full scale. At that point soft-start is complete.

During the ramp the low-side switch is held off until the modulator reports its first high-side pulse. This keeps an output that is already biased from being pulled down. If no pulse comes, the low side is released when the ramp ends. Protection logic can still force the low side on at any time.

Loss of enable or of either supply drops the block into an idle soft-off state with the bleed path on. An external fault request (overvoltage, undervoltage or overcurrent) sends it to a latched soft-off that only an enable or signal-supply cycle clears. The over-temperature flag instead parks the block with both switches off, and it restarts by itself with a new wait and ramp once the flag clears.

Top module: `vreg_start_seq`

## Requirements
- R1: After reset, `seq_state_o` reads 0 (idle), `ref_code_o` is 0, `ls_en_o` and `ss_done_o` are low and `bleed_en_o` is high. State codes are: 0 idle, 1 wait, 2 ramp, 3 run, 4 latched fault, 5 thermal hold.
- R2: The block leaves idle only when the power-good, signal-good and enable inputs are all high. Each of them passes through two flip-flops, so the state reads 1 after the third rising edge following the last of them going high.
- R3: The wait state lasts exactly `DELAY_CYC` clock cycles. It is followed by the ramp state with the reference code at 0.
- R4: In the ramp state the reference code rises by exactly one on each cycle that has `sw_tick_i` high, and holds otherwise. Ticks in any other state leave the output code unchanged.
- R5: In the ramp state `ls_en_o` stays low until a cycle with `pwm_pulse_i` high. From the next cycle it stays high for the rest of the ramp.
- R6: The tick that arrives with the code at full scale (1023, the 1024th tick) moves the block to run. In run the code stays at 1023 and `ss_done_o` and `ls_en_o` are high, even when no PWM pulse was ever seen.
- R7: A high `fault_req_i` in the wait, ramp or run state moves the block to the latched state on the next edge. In that state the code is 0, `ls_en_o` and `ss_done_o` are low and `bleed_en_o` is high.
- R8: The latched state holds while enable and the signal supply stay high, whatever the tick and pulse inputs do. It returns to idle three edges after enable (or the signal supply) goes low, and a later enable starts a fresh wait and ramp.
- R9: A high `prot_ls_req_i` drives `ls_en_o` high in the same cycle, in any state.
- R10: Loss of enable or of either supply during wait, ramp or run returns the block to idle three edges after the input falls. Idle has the code at 0, the low side off and the bleed on.
- R11: A synchronised over-temperature flag in wait, ramp or run moves the block to thermal hold, three edges after the flag rises. Thermal hold has the code at 0, the low side and bleed off and `ss_done_o` low. Three edges after the flag clears, the block re-enters the wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok_i | input | 1 | Power supply above its lockout level (asynchronous) |
| sig_ok_i | input | 1 | Signal supply above its lockout level (asynchronous) |
| enable_i | input | 1 | Enable request (asynchronous) |
| sw_tick_i | input | 1 | One-cycle pulse per switching period |
| pwm_pulse_i | input | 1 | Modulator produced a high-side pulse this cycle |
| fault_req_i | input | 1 | Latching fault request (overvoltage, undervoltage, overcurrent) |
| prot_ls_req_i | input | 1 | Protection request to turn the low side on |
| over_temp_i | input | 1 | Over-temperature flag with external hysteresis (asynchronous) |
| ref_code_o | output | REF_W | Reference ramp code for the DAC |
| ls_en_o | output | 1 | Low-side switching permitted |
| ss_done_o | output | 1 | Soft-start complete |
| bleed_en_o | output | 1 | Soft-off bleed path at the switch node |
| seq_state_o | output | 3 | Current sequencer state code |

## Verification
The asynchronous inputs (enable, the two supply flags and the thermal flag) take effect on the state three rising edges after they change. Fault requests, ticks and PWM pulses are registered directly and show on the outputs after the next edge. A protection low-side request reaches `ls_en_o` in the same cycle. The driver queues one expected output vector per cycle, shaped to these latencies: two unchanged vectors, then the new state for a synchronised input, and the updated vector straight away for the direct inputs. The monitor compares each queued vector shortly after the rising edge it belongs to, so every wait count, ramp step and state change is checked in the exact cycle it is due.

// File: rtl/vreg_seq_pkg.sv
package vreg_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_RAMP  = 3'd2,
    ST_RUN   = 3'd3,
    ST_LATCH = 3'd4,
    ST_THERM = 3'd5
  } seq_state_e;

  // positions of the asynchronous inputs in the synchroniser vector
  localparam int SYNC_PWR = 0;
  localparam int SYNC_SIG = 1;
  localparam int SYNC_EN  = 2;
  localparam int SYNC_HOT = 3;
  localparam int SYNC_NUM = 4;

  function automatic logic start_allowed(logic pwr, logic sig, logic en);
    return pwr & sig & en;
  endfunction

  function automatic logic bleed_for(seq_state_e s);
    return (s == ST_IDLE) || (s == ST_LATCH);
  endfunction

  function automatic logic loop_ls_for(seq_state_e s, logic armed);
    return (s == ST_RUN) || ((s == ST_RAMP) && armed);
  endfunction

  function automatic logic active_state(seq_state_e s);
    return (s == ST_WAIT) || (s == ST_RAMP) || (s == ST_RUN);
  endfunction

endpackage

// File: rtl/vreg_in_sync.sv
module vreg_in_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
      end
      assign sync_o[b] = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/vreg_delay_cnt.sv
module vreg_delay_cnt #(
  parameter int CYCLES = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expired_o
);

  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!run_i)     cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/vreg_ref_ramp.sv
module vreg_ref_ramp #(
  parameter int REF_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ramp_i,
  input  logic             hold_i,
  input  logic             step_i,
  output logic [REF_W-1:0] code_o,
  output logic             top_step_o
);

  localparam logic [REF_W-1:0] FULL = '1;

  logic [REF_W-1:0] code_q;

  function automatic logic [REF_W-1:0] step_up(logic [REF_W-1:0] c);
    return (c == FULL) ? c : c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_q <= '0;
    else if (ramp_i) code_q <= step_i ? step_up(code_q) : code_q;
    else if (hold_i) code_q <= FULL;
    else             code_q <= '0;
  end

  // the tick seen at full scale closes the ramp
  assign top_step_o = ramp_i && step_i && (code_q == FULL);
  assign code_o     = (ramp_i || hold_i) ? code_q : '0;

endmodule

// File: rtl/vreg_start_seq.sv
module vreg_start_seq
  import vreg_seq_pkg::*;
#(
  parameter int DELAY_CYC   = 25000,
  parameter int REF_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_ok_i,
  input  logic             sig_ok_i,
  input  logic             enable_i,
  input  logic             sw_tick_i,
  input  logic             pwm_pulse_i,
  input  logic             fault_req_i,
  input  logic             prot_ls_req_i,
  input  logic             over_temp_i,
  output logic [REF_W-1:0] ref_code_o,
  output logic             ls_en_o,
  output logic             ss_done_o,
  output logic             bleed_en_o,
  output logic [2:0]       seq_state_o
);

  logic [SYNC_NUM-1:0] raw_in;
  logic [SYNC_NUM-1:0] syn_in;

  assign raw_in[SYNC_PWR] = pwr_ok_i;
  assign raw_in[SYNC_SIG] = sig_ok_i;
  assign raw_in[SYNC_EN]  = enable_i;
  assign raw_in[SYNC_HOT] = over_temp_i;

  vreg_in_sync #(
    .WIDTH (SYNC_NUM),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(raw_in),
    .sync_o (syn_in)
  );

  logic pwr_s, sig_s, en_s, hot_s, go_ok;
  assign pwr_s = syn_in[SYNC_PWR];
  assign sig_s = syn_in[SYNC_SIG];
  assign en_s  = syn_in[SYNC_EN];
  assign hot_s = syn_in[SYNC_HOT];
  assign go_ok = start_allowed(pwr_s, sig_s, en_s);

  seq_state_e state_q, state_d;
  logic wait_run, wait_done, ramp_run, ramp_hold, ramp_step, ramp_top;
  logic ls_armed_q;

  assign wait_run  = (state_q == ST_WAIT);
  assign ramp_run  = (state_q == ST_RAMP);
  assign ramp_hold = (state_q == ST_RUN);
  assign ramp_step = ramp_run && sw_tick_i;

  vreg_delay_cnt #(
    .CYCLES(DELAY_CYC)
  ) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (wait_run),
    .expired_o(wait_done)
  );

  vreg_ref_ramp #(
    .REF_W(REF_W)
  ) u_ramp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ramp_i    (ramp_run),
    .hold_i    (ramp_hold),
    .step_i    (ramp_step),
    .code_o    (ref_code_o),
    .top_step_o(ramp_top)
  );

  // priority in the active states: supply/enable loss, then fault, then heat
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (go_ok && !hot_s) state_d = ST_WAIT;
      ST_WAIT, ST_RAMP, ST_RUN: begin
        if (!go_ok)                          state_d = ST_IDLE;
        else if (fault_req_i)                state_d = ST_LATCH;
        else if (hot_s)                      state_d = ST_THERM;
        else if (wait_run && wait_done)      state_d = ST_RAMP;
        else if (ramp_top)                   state_d = ST_RUN;
      end
      ST_LATCH: if (!en_s || !sig_s) state_d = ST_IDLE;
      ST_THERM: begin
        if (!go_ok)      state_d = ST_IDLE;
        else if (!hot_s) state_d = ST_WAIT;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      ls_armed_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      ls_armed_q <= ramp_run && (ls_armed_q || pwm_pulse_i);
    end
  end

  assign ls_en_o     = loop_ls_for(state_q, ls_armed_q) || prot_ls_req_i;
  assign ss_done_o   = ramp_hold;
  assign bleed_en_o  = bleed_for(state_q);
  assign seq_state_o = state_q;

endmodule

// File: rtl/vreg_start_seq_chk.sv
module vreg_start_seq_chk
  import vreg_seq_pkg::*;
#(
  parameter int REF_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable_i,
  input logic             prot_ls_req_i,
  input logic             ramp_step,
  input logic [2:0]       seq_state_o,
  input logic [REF_W-1:0] ref_code_o,
  input logic             ls_en_o,
  input logic             ss_done_o,
  input logic             bleed_en_o
);

  assert_wait_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state_o == ST_WAIT && $past(seq_state_o) == ST_IDLE) |-> $past(enable_i, SYNC_STAGES));

  assert_ramp_from_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state_o == ST_RAMP && $past(seq_state_o) != ST_RAMP)
      |-> ($past(seq_state_o) == ST_WAIT && ref_code_o == '0));

  assert_ref_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state_o == ST_RAMP && $past(seq_state_o) == ST_RAMP && ref_code_o != $past(ref_code_o))
      |-> (ref_code_o == $past(ref_code_o) + 1'b1 && $past(ramp_step)));

  assert_done_at_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ss_done_o |-> (ref_code_o == '1 && ls_en_o));

  assert_softoff_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bleed_en_o && !prot_ls_req_i) |-> (!ls_en_o && !ss_done_o && ref_code_o == '0));

  assert_latch_exit_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(seq_state_o) == ST_LATCH && seq_state_o != ST_LATCH) |-> seq_state_o == ST_IDLE);

  assert_prot_forces_ls_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prot_ls_req_i |-> ls_en_o);

  assert_thermal_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state_o == ST_THERM) |-> ((!ls_en_o || prot_ls_req_i) && !bleed_en_o && !ss_done_o));

endmodule

bind vreg_start_seq vreg_start_seq_chk #(
  .REF_W      (REF_W),
  .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable_i     (enable_i),
  .prot_ls_req_i(prot_ls_req_i),
  .ramp_step    (ramp_step),
  .seq_state_o  (seq_state_o),
  .ref_code_o   (ref_code_o),
  .ls_en_o      (ls_en_o),
  .ss_done_o    (ss_done_o),
  .bleed_en_o   (bleed_en_o)
);

// File: tb/vreg_start_seq_tb.sv
module vreg_start_seq_tb;

  localparam int D    = 8;
  localparam int RW   = 10;
  localparam int FULL = 1023;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok_i = 0, sig_ok_i = 0, enable_i = 0, sw_tick_i = 0;
  logic pwm_pulse_i = 0, fault_req_i = 0, prot_ls_req_i = 0, over_temp_i = 0;
  logic [RW-1:0] ref_code_o;
  logic ls_en_o, ss_done_o, bleed_en_o;
  logic [2:0] seq_state_o;

  always #10 clk = ~clk;

  vreg_start_seq #(
    .DELAY_CYC(D),
    .REF_W    (RW)
  ) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_ok_i     (pwr_ok_i),
    .sig_ok_i     (sig_ok_i),
    .enable_i     (enable_i),
    .sw_tick_i    (sw_tick_i),
    .pwm_pulse_i  (pwm_pulse_i),
    .fault_req_i  (fault_req_i),
    .prot_ls_req_i(prot_ls_req_i),
    .over_temp_i  (over_temp_i),
    .ref_code_o   (ref_code_o),
    .ls_en_o      (ls_en_o),
    .ss_done_o    (ss_done_o),
    .bleed_en_o   (bleed_en_o),
    .seq_state_o  (seq_state_o)
  );

  typedef struct packed {
    logic [2:0]    st;
    logic [RW-1:0] rf;
    logic          ls;
    logic          dn;
    logic          bl;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  exp_t  mon_e;
  string mon_t;
  int checks = 0;
  int errors = 0;
  int r = 0;
  bit finished = 0;

  // driver: queue the vector expected after the coming rising edge
  task automatic cyc(input bit chk, input logic [2:0] st, input int rf,
                     input bit ls, input bit dn, input bit bl, input string tag);
    exp_t e;
    if (chk) begin
      e = '{st, RW'(rf), ls, dn, bl};
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  // monitor: compare just after each rising edge
  initial forever begin
    @(posedge clk);
    #2;
    if (exp_q.size() > 0) begin
      mon_e = exp_q.pop_front();
      mon_t = tag_q.pop_front();
      checks++;
      if ({seq_state_o, ref_code_o, ls_en_o, ss_done_o, bleed_en_o} !== mon_e) begin
        errors++;
        $display("FAIL %s: got st=%0d ref=%0d ls=%0b done=%0b bleed=%0b, expected st=%0d ref=%0d ls=%0b done=%0b bleed=%0b",
                 mon_t, seq_state_o, ref_code_o, ls_en_o, ss_done_o, bleed_en_o,
                 mon_e.st, mon_e.rf, mon_e.ls, mon_e.dn, mon_e.bl);
      end
    end
  end

  // called once the first wait cycle has been queued
  task automatic wait_to_ramp();
    for (int i = 1; i < D; i++) begin
      sw_tick_i = (i % 2 == 1);
      cyc(1, 3'd1, 0, 0, 0, 0, "R3 wait length, R4 tick ignored in wait");
    end
    sw_tick_i = 0;
    cyc(1, 3'd2, 0, 0, 0, 0, "R3 ramp entry at code 0");
    r = 0;
  endtask

  task automatic ramp_ticks(input int n, input bit ls);
    for (int k = 0; k < n; k++) begin
      sw_tick_i = 1;
      r++;
      cyc(1, 3'd2, r, ls, 0, 0, ls ? "R4 step with low side armed" : "R4 step, R5 low side blanked");
      sw_tick_i = 0;
      cyc(1, 3'd2, r, ls, 0, 0, "R4 hold between ticks");
    end
  endtask

  task automatic finish_ramp(input bit ls);
    ramp_ticks(FULL - r, ls);
    sw_tick_i = 1;
    cyc(1, 3'd3, FULL, 1, 1, 0, "R6 run after 1024th tick");
    sw_tick_i = 0;
  endtask

  task automatic start_from(input logic [2:0] st, input bit bl, input string tag);
    cyc(1, st, 0, 0, 0, bl, tag);
    cyc(1, st, 0, 0, 0, bl, tag);
    cyc(1, 3'd1, 0, 0, 0, 0, "R2 wait on third edge");
    wait_to_ramp();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    cyc(1, 3'd0, 0, 0, 0, 1, "R1 reset state");
    cyc(1, 3'd0, 0, 0, 0, 1, "R1 idle holds");

    pwr_ok_i = 1;
    sig_ok_i = 1;
    repeat (4) cyc(1, 3'd0, 0, 0, 0, 1, "R2 no start without enable");
    enable_i = 1;
    start_from(3'd0, 1, "R2 synchroniser delay");
    finish_ramp(0);
    sw_tick_i = 1;
    cyc(1, 3'd3, FULL, 1, 1, 0, "R6 run holds full scale");
    sw_tick_i = 0;

    sig_ok_i = 0;
    cyc(1, 3'd3, FULL, 1, 1, 0, "R10 supply loss sync");
    cyc(1, 3'd3, FULL, 1, 1, 0, "R10 supply loss sync");
    cyc(1, 3'd0, 0, 0, 0, 1, "R10 idle after signal supply loss");
    sig_ok_i = 1;
    start_from(3'd0, 1, "R10 restart after supply returns");

    ramp_ticks(5, 0);
    pwm_pulse_i = 1;
    cyc(1, 3'd2, r, 1, 0, 0, "R5 low side after first pwm pulse");
    pwm_pulse_i = 0;
    ramp_ticks(3, 1);
    enable_i = 0;
    cyc(1, 3'd2, r, 1, 0, 0, "R10 enable drop sync");
    cyc(1, 3'd2, r, 1, 0, 0, "R10 enable drop sync");
    cyc(1, 3'd0, 0, 0, 0, 1, "R10 idle after enable drop");

    enable_i = 1;
    start_from(3'd0, 1, "R2 second enable");
    finish_ramp(0);
    fault_req_i = 1;
    cyc(1, 3'd4, 0, 0, 0, 1, "R7 latched fault entry");
    fault_req_i = 0;
    pwm_pulse_i = 1;
    for (int i = 0; i < 6; i++) begin
      sw_tick_i = (i % 2 == 0);
      cyc(1, 3'd4, 0, 0, 0, 1, "R8 latch holds, R4 ticks ignored");
    end
    sw_tick_i = 0;
    pwm_pulse_i = 0;
    prot_ls_req_i = 1;
    cyc(1, 3'd4, 0, 1, 0, 1, "R9 protection low side in latch");
    prot_ls_req_i = 0;
    cyc(1, 3'd4, 0, 0, 0, 1, "R9 protection released");
    enable_i = 0;
    cyc(1, 3'd4, 0, 0, 0, 1, "R8 enable cycle sync");
    cyc(1, 3'd4, 0, 0, 0, 1, "R8 enable cycle sync");
    cyc(1, 3'd0, 0, 0, 0, 1, "R8 unlatched to idle");
    enable_i = 1;
    start_from(3'd0, 1, "R8 fresh start after unlatch");

    ramp_ticks(4, 0);
    over_temp_i = 1;
    cyc(1, 3'd2, r, 0, 0, 0, "R11 thermal flag sync");
    cyc(1, 3'd2, r, 0, 0, 0, "R11 thermal flag sync");
    cyc(1, 3'd5, 0, 0, 0, 0, "R11 thermal hold entry");
    for (int i = 0; i < 4; i++) begin
      sw_tick_i = (i % 2 == 0);
      cyc(1, 3'd5, 0, 0, 0, 0, "R11 thermal hold");
    end
    sw_tick_i = 0;
    prot_ls_req_i = 1;
    cyc(1, 3'd5, 0, 1, 0, 0, "R9 protection low side in thermal hold");
    prot_ls_req_i = 0;
    over_temp_i = 0;
    start_from(3'd5, 0, "R11 auto restart after cooling");
    ramp_ticks(2, 0);

    cyc(0, 3'd0, 0, 0, 0, 0, "");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got no end of run, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule